// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

At power-up this block visits every erase block of a NAND array and records which ones carry a factory invalid-block mark. It drives a plain page-read request port. Each request carries a row address and a column address, and the responder returns one byte.

For every block the scanner reads the first byte of the spare area on the block's first page. When that byte is FFh it also reads the same byte on the second page. Any value other than FFh on either page marks the block as bad. Block 0 is guaranteed valid, so it is never flagged.

The scanner sets one bit per bad block in an internal bitmap and keeps a running count. When the last block is done, it raises `done` and asserts `err` if the count is above the allowed limit. After the scan, a controller reads the bitmap one block at a time through a lookup port. A new `start` clears the earlier results and runs the scan again.

Top module: `nand_badblock_scan`

## Requirements
- R1: After reset the scanner is idle: `rd_req`, `busy`, `done` and `err` are low and `bad_count` is 0.
- R2: Every read request uses column 2048, the first spare-area byte. The row is block × 64 + page, with page 0 or page 1. The block number occupies `rd_row[16:6]` and the page occupies `rd_row[5:0]`.
- R3: Blocks are visited in ascending order from 0 to 2047. Block n+1 is never requested before block n. `done` rises after the last block and stays high until the next `start`, and it is never high together with `busy`.
- R4: A block other than 0 is flagged bad, and `bad_count` goes up by one, when either page returns a byte other than FFh.
- R5: When page 0 of a block other than 0 returns a byte other than FFh, page 1 of that block is not read.
- R6: Both pages of block 0 are read, but block 0 is never flagged and never counted, whatever bytes it returns.
- R7: `err` is high exactly while `done` is high and `bad_count` is above 40. A count of exactly 40 gives no error. The flag, the count, `done` and `err` for the last block all take effect on the same clock edge.
- R8: `start` clears the whole bitmap and the count, so no result from an earlier scan survives.
- R9: While `done` is high, `lk_bad` gives the flag of block `lk_idx`. While a scan is running, `lk_bad` reads 0.
- R10: A `start` pulse that arrives while a scan is running is ignored. The scan neither restarts nor repeats any reads.
- R11: `rd_req` stays high, with `rd_row` unchanged, until the cycle in which `rd_ack` is high. `rd_data` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that starts a scan (ignored while busy) |
| rd_req | output | 1 | Read request for one byte |
| rd_row | output | 17 | Row address: {block, page} |
| rd_col | output | 12 | Column address (always 2048) |
| rd_ack | input | 1 | Responder returns the byte this cycle |
| rd_data | input | 8 | Byte read from the array |
| lk_idx | input | 11 | Block index for bitmap lookup |
| lk_bad | output | 1 | Flag of block `lk_idx` (valid when done) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished; results valid |
| err | output | 1 | Bad-block count is above the limit |
| bad_count | output | 12 | Number of bad blocks found |

## Verification
The end of the scan and the handling of a bad marker on the last block can fall on the same clock edge. On that edge the 41st flag is written, the count crosses the limit, `done` rises and `err` rises.

The bench provokes this by returning a bad byte on page 1 of block 2047 after 40 earlier bad blocks. At the first falling edge where `done` is seen, it requires `err` already high and block 2047 already flagged, with no cycle between them.

A second run with exactly 40 bad blocks checks the same edge with `err` staying low. The responder delays its acknowledge by a varying number of cycles, so that held requests and accepted reads interleave.

// File: rtl/nand_badblock_scan.sv
module nand_badblock_scan #(
  parameter int BLOCKS    = 2048,
  parameter int PAGES     = 64,
  parameter int COL_W     = 12,
  parameter int MARK_COL  = 2048,
  parameter int BAD_LIMIT = 40
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  output logic                                     rd_req,
  output logic [$clog2(BLOCKS)+$clog2(PAGES)-1:0]  rd_row,
  output logic [COL_W-1:0]                         rd_col,
  input  logic                                     rd_ack,
  input  logic [7:0]                               rd_data,
  input  logic [$clog2(BLOCKS)-1:0]                lk_idx,
  output logic                                     lk_bad,
  output logic                                     busy,
  output logic                                     done,
  output logic                                     err,
  output logic [$clog2(BLOCKS):0]                  bad_count
);
  localparam int BLK_W = $clog2(BLOCKS);
  localparam int PG_W  = $clog2(PAGES);
  localparam int CNT_W = BLK_W + 1;
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_P0, S_P1} state_t;

  state_t             st_q;
  logic [BLK_W-1:0]   blk_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BLOCKS-1:0]  map_q;
  logic               done_q;
  logic               marker_bad;
  logic               last_blk;

  assign marker_bad = (rd_data != 8'hFF) && (blk_q != '0);
  assign last_blk   = (blk_q == LAST_BLK);

  assign busy      = (st_q != S_IDLE);
  assign rd_req    = busy;
  assign rd_row    = {blk_q, PG_W'(st_q == S_P1)};
  assign rd_col    = COL_W'(MARK_COL);
  assign done      = done_q;
  assign bad_count = cnt_q;
  assign err       = done_q && (cnt_q > CNT_W'(BAD_LIMIT));
  assign lk_bad    = done_q & map_q[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      blk_q  <= '0;
      cnt_q  <= '0;
      map_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          map_q  <= '0;
          cnt_q  <= '0;
          blk_q  <= '0;
          done_q <= 1'b0;
          st_q   <= S_P0;
        end
        S_P0, S_P1: if (rd_ack) begin
          if (marker_bad) begin
            map_q[blk_q] <= 1'b1;
            cnt_q        <= cnt_q + CNT_W'(1);
          end
          if (st_q == S_P0 && !marker_bad) begin
            st_q <= S_P1;
          end else if (last_blk) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            blk_q <= blk_q + BLK_W'(1);
            st_q  <= S_P0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_row));

  assert_blk0_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !map_q[0]);

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (bad_count == $past(bad_count)) || (bad_count == $past(bad_count) + CNT_W'(1)));

  assert_skip_page1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_P0) && rd_ack && (rd_data != 8'hFF) && (blk_q != '0) |=> (st_q != S_P1));
endmodule

// File: tb/sim_nand_badblock_scan.sv
module sim_nand_badblock_scan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_req;
  logic [16:0] rd_row;
  logic [11:0] rd_col;
  logic        rd_ack = 1'b0;
  logic [7:0]  rd_data = 8'hFF;
  logic [10:0] lk_idx = '0;
  logic        lk_bad, busy, done, err;
  logic [11:0] bad_count;

  always #10 clk = ~clk;

  nand_badblock_scan u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .lk_idx(lk_idx), .lk_bad(lk_bad),
    .busy(busy), .done(done), .err(err), .bad_count(bad_count)
  );

  int nchk = 0, nfail = 0;
  int sc = 1;
  int reads, addr_bad, hs_bad, last_blk, wcnt;
  logic [16:0] held;

  function automatic logic [7:0] mark(int s, int b, int p);
    if (s == 2) begin
      if (b == 0) return 8'h00;
      if (b == 5 && p == 0) return 8'h00;
      if (b == 6 && p == 1) return 8'hFE;
      if (b == 2047 && p == 0) return 8'h7F;
    end
    if (s == 3 || s == 4) begin
      if (b % 50 == 1 && b <= 1951 && p == (b / 50) % 2) return 8'h3C;
      if (s == 4 && b == 2047 && p == 1) return 8'h00;
    end
    return 8'hFF;
  endfunction

  function automatic bit exp_bad(int s, int b);
    return b != 0 && (mark(s, b, 0) != 8'hFF || mark(s, b, 1) != 8'hFF);
  endfunction

  function automatic int exp_count(int s);
    int n = 0;
    for (int b = 0; b < 2048; b++) if (exp_bad(s, b)) n++;
    return n;
  endfunction

  function automatic int exp_reads(int s);
    int n = 0;
    for (int b = 0; b < 2048; b++)
      n += (b != 0 && mark(s, b, 0) != 8'hFF) ? 1 : 2;
    return n;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // responder with a latency of (block % 3) cycles
  always @(negedge clk) begin
    int b, p;
    if (rd_ack) begin
      rd_ack = 1'b0;
    end else if (rd_req) begin
      b = int'(rd_row[16:6]);
      p = int'(rd_row[5:0]);
      if (wcnt > 0 && rd_row != held) hs_bad++;
      held = rd_row;
      if (wcnt < b % 3) begin
        wcnt++;
      end else begin
        wcnt = 0;
        rd_ack = 1'b1;
        rd_data = mark(sc, b, p);
        reads++;
        if (rd_col != 12'd2048 || p > 1) addr_bad++;
        if (!(b == last_blk || b == last_blk + 1)) addr_bad++;
        last_blk = b;
      end
    end
  end

  task automatic scan(int s, bit poke, bit mid_lk, output bit err_at_done);
    int n = 0;
    sc = s; reads = 0; addr_bad = 0; hs_bad = 0; last_blk = 0; wcnt = 0;
    err_at_done = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 40000) begin
      @(negedge clk); n++;
      if (poke && n == 3000) begin
        start = 1'b1; @(negedge clk); start = 1'b0; n++;
      end
      if (mid_lk && n == 2500) begin
        lk_idx = 11'd5; #1;
        chk(busy && !lk_bad, "R9", "lookup while busy", int'(lk_bad), 0);
      end
    end
    chk(n < 40000, "R3", "scan finished (watchdog)", n, 0);
    err_at_done = err;
    chk(addr_bad == 0, "R2", "address errors", addr_bad, 0);
    chk(hs_bad == 0, "R11", "row changed while held", hs_bad, 0);
    chk(last_blk == 2047, "R3", "last block read", last_blk, 2047);
    chk(reads == exp_reads(s), "R5", "read count", reads, exp_reads(s));
    chk(int'(bad_count) == exp_count(s), "R4", "bad count", int'(bad_count), exp_count(s));
  endtask

  task automatic check_map(int s, string req);
    int mism = 0;
    for (int b = 0; b < 2048; b++) begin
      lk_idx = 11'(b); #1;
      if (lk_bad !== exp_bad(s, b)) mism++;
    end
    chk(mism == 0, req, "bitmap mismatches", mism, 0);
    @(negedge clk);
    chk(done, "R3", "done held", int'(done), 1);
  endtask

  task automatic t_reset;
    #5;
    chk(!rd_req && !busy && !done && !err && bad_count == 0, "R1", "reset state",
        int'({rd_req, busy, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req, "R1", "idle after reset", int'(busy), 0);
  endtask

  task automatic t_all_good;
    bit e;
    scan(1, 1'b0, 1'b0, e);
    chk(!e, "R7", "err with no bad blocks", int'(e), 0);
    check_map(1, "R9");
  endtask

  task automatic t_mixed;
    bit e;
    scan(2, 1'b0, 1'b1, e);
    lk_idx = 11'd0; #1;
    chk(!lk_bad, "R6", "block 0 flag", int'(lk_bad), 0);
    check_map(2, "R4");
  endtask

  task automatic t_limit_exact;
    bit e;
    scan(3, 1'b1, 1'b0, e);
    chk(int'(bad_count) == 40, "R10", "count after ignored start", int'(bad_count), 40);
    chk(!e, "R7", "err at exactly 40", int'(e), 0);
    check_map(3, "R4");
  endtask

  task automatic t_limit_over;
    bit e;
    scan(4, 1'b0, 1'b0, e);
    chk(e, "R7", "err on done edge at 41", int'(e), 1);
    lk_idx = 11'd2047; #1;
    chk(lk_bad, "R7", "last block flag on done edge", int'(lk_bad), 1);
    check_map(4, "R4");
  endtask

  task automatic t_rescan_clears;
    bit e;
    scan(1, 1'b0, 1'b0, e);
    chk(!e && bad_count == 0, "R8", "count cleared by start", int'(bad_count), 0);
    check_map(1, "R8");
  endtask

  initial begin
    t_reset();
    t_all_good();
    t_mixed();
    t_limit_exact();
    t_limit_over();
    t_rescan_clears();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule